// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This block is a memory-mapped watchdog that does not count down on its own. It compares a free-running 64-bit system count, supplied from outside, against a 64-bit expiry point. When the count reaches that point, the block raises a warning level meant for an interrupt controller. It then moves the expiry point forward by a programmable 32-bit interval, measured from the count at that moment. If that second interval also runs out, the block raises a final level meant to request a system reset.

Software talks to the block over a single-cycle register bus that carries two frames. The control frame holds the status/enable word, the interval register and the two halves of the expiry point. The refresh frame holds a register whose only job is to be written. A refresh moves the expiry point to the current count plus the interval and clears both stages. Any write to the refresh register, the status/enable word or the interval register counts as a refresh. Software may also write the expiry point directly, one word at a time.

Top module: `wdog_dual_stage`

## Requirements
- R1: After reset the enable bit, the warning level and the final level are all 0, and the expiry point and the interval both read 0.
- R2: In the control frame, the word at offset 0x000 reads back with bit 0 as enable, bit 1 as the warning level and bit 2 as the final level. A write to this word sets enable from bit 0 of the write data.
- R3: A refresh does three things: it loads the expiry point with the system count plus the zero-extended interval, and it clears the warning and final levels. A refresh is any write to offset 0x000 of the refresh frame (busRefreshSel=1), or to offsets 0x000 or 0x008 of the control frame. A write to 0x008 uses the newly written interval.
- R4: When enabled, with the warning clear, a count at or above the expiry point sets the warning on the next clock edge. On that same edge the expiry point is reloaded with the count plus the interval.
- R5: When enabled, with the warning set, a count at or above the expiry point sets the final level on the next clock edge. The warning stays set.
- R6: While enable is 0, neither level is raised, whatever the count. The expiry point keeps its last value and reads it back.
- R7: The expiry point is written and read as a low word at control offset 0x010 and a high word at 0x014. If the written value is at or below the current count, the next stage fires on the following edge.
- R8: Read data appears on busRdata the cycle after the read. Offset 0xFCC of either frame returns the IdValue parameter. Every other unmapped offset, and the refresh register itself, reads as 0.
- R9: In any cycle that carries a bus write, no stage fires. The expiry is evaluated again on the next cycle.
- R10: The interval register at control offset 0x008 reads back what was written. It is added to the count as an unsigned value, so a carry reaches the high word of the expiry point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sysCount | input | 64 | Free-running system count |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busRefreshSel | input | 1 | 1 selects the refresh frame, 0 the control frame |
| busAddr | input | 12 | Byte offset within the frame |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the read |
| warnIrq | output | 1 | First-stage warning level |
| resetReq | output | 1 | Second-stage final level |

## Verification
The assertions assume that bus inputs never go unknown once reset is released. They also assume that the system count changes only between clock edges, and they make no assumption about whether the count is monotonic. The bench drives the count as an explicit value on the falling edge. It steps the count across each expiry point by one unit. It issues a single bus access per cycle, and it deliberately lines up one write with an expiry so that the write-priority rule is exercised.

// File: rtl/wdog_dual_stage_pkg.sv
package wdog_dual_stage_pkg;
  localparam int CMP_WORDS = 2;

  typedef struct packed {
    logic                 refresh;
    logic                 writeOffset;
    logic [CMP_WORDS-1:0] loadWord;
    logic                 arm;
  } wdStrobes_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_dual_stage_pkg::*;
#(
  parameter int DataW  = 32,
  parameter int CountW = CMP_WORDS * DataW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CountW-1:0] sysCount,
  input  logic [DataW-1:0]  busWdata,
  input  wdStrobes_t        stb,
  output logic              expired,
  output logic [CountW-1:0] compareVal,
  output logic [DataW-1:0]  offsetVal
);
  logic [CountW-1:0] compareQ, compareNext, reloadSum;
  logic [DataW-1:0]  offsetQ, offsetUse;

  assign offsetUse = stb.writeOffset ? busWdata : offsetQ;
  assign reloadSum = sysCount + CountW'(offsetUse);
  assign expired   = sysCount >= compareQ;

  always_comb begin
    compareNext = compareQ;
    if (stb.refresh || stb.arm) begin
      compareNext = reloadSum;
    end else begin
      for (int i = 0; i < CMP_WORDS; i++) begin
        if (stb.loadWord[i]) compareNext[i*DataW +: DataW] = busWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compareQ <= '0;
      offsetQ  <= '0;
    end else begin
      compareQ <= compareNext;
      if (stb.writeOffset) offsetQ <= busWdata;
    end
  end

  assign compareVal = compareQ;
  assign offsetVal  = offsetQ;

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.refresh && !stb.arm && stb.loadWord == '0) |=> $stable(compareQ));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_dual_stage_pkg::*;
#(
  parameter int          AddrW   = 12,
  parameter int          DataW   = 32,
  parameter logic [31:0] IdValue = 32'h5744_0101,
  parameter int          CountW  = CMP_WORDS * DataW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busRefreshSel,
  input  logic [AddrW-1:0]  busAddr,
  input  logic [DataW-1:0]  busWdata,
  input  logic              expired,
  input  logic [CountW-1:0] compareVal,
  input  logic [DataW-1:0]  offsetVal,
  output wdStrobes_t        stb,
  output logic              warnQ,
  output logic              finalQ,
  output logic [DataW-1:0]  busRdata
);
  localparam logic [AddrW-1:0] StatusAddr = AddrW'(12'h000);
  localparam logic [AddrW-1:0] OffsetAddr = AddrW'(12'h008);
  localparam logic [AddrW-1:0] CmpAddr    = AddrW'(12'h010);
  localparam logic [AddrW-1:0] IdAddr     = AddrW'(12'hFCC);
  localparam logic [AddrW-1:0] KickAddr   = AddrW'(12'h000);

  logic enableQ;
  logic anyWrite, ctlWrite, wrStatus, wrOffset, wrKick, fireFinal;
  logic [DataW-1:0] rdNext;

  assign anyWrite = busValid && busWrite;
  assign ctlWrite = anyWrite && !busRefreshSel;
  assign wrStatus = ctlWrite && busAddr == StatusAddr;
  assign wrOffset = ctlWrite && busAddr == OffsetAddr;
  assign wrKick   = anyWrite && busRefreshSel && busAddr == KickAddr;

  genvar gw;
  generate
    for (gw = 0; gw < CMP_WORDS; gw++) begin : g_word
      assign stb.loadWord[gw] = ctlWrite && busAddr == CmpAddr + AddrW'(4 * gw);
    end
  endgenerate

  assign stb.refresh     = wrStatus || wrOffset || wrKick;
  assign stb.writeOffset = wrOffset;
  assign stb.arm         = enableQ && expired && !warnQ && !anyWrite;
  assign fireFinal       = enableQ && expired && warnQ && !finalQ && !anyWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      warnQ   <= 1'b0;
      finalQ  <= 1'b0;
    end else begin
      if (wrStatus) enableQ <= busWdata[0];
      if (stb.refresh) begin
        warnQ  <= 1'b0;
        finalQ <= 1'b0;
      end else if (stb.arm) begin
        warnQ <= 1'b1;
      end else if (fireFinal) begin
        finalQ <= 1'b1;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (!busRefreshSel) begin
      if (busAddr == StatusAddr) rdNext[2:0] = {finalQ, warnQ, enableQ};
      if (busAddr == OffsetAddr) rdNext = offsetVal;
      for (int i = 0; i < CMP_WORDS; i++) begin
        if (busAddr == CmpAddr + AddrW'(4 * i)) rdNext = compareVal[i*DataW +: DataW];
      end
    end
    if (busAddr == IdAddr) rdNext = DataW'(IdValue);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= (busValid && !busWrite) ? rdNext : '0;
  end

  // R5
  final_needs_warn_chk: assert property (@(posedge clk) disable iff (!rstN)
    finalQ |-> warnQ);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |-> (!warnQ && !finalQ));
  // R3
  refresh_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.refresh |=> (!warnQ && !finalQ));
  // R4
  warn_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnQ) |-> $past(expired && enableQ));
  // R9
  write_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyWrite && !stb.refresh) |=> ($stable(warnQ) && $stable(finalQ)));
endmodule

// File: rtl/wdog_dual_stage.sv
module wdog_dual_stage
  import wdog_dual_stage_pkg::*;
#(
  parameter int          AddrW   = 12,
  parameter int          DataW   = 32,
  parameter logic [31:0] IdValue = 32'h5744_0101,
  localparam int         CountW  = CMP_WORDS * DataW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CountW-1:0] sysCount,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busRefreshSel,
  input  logic [AddrW-1:0]  busAddr,
  input  logic [DataW-1:0]  busWdata,
  output logic [DataW-1:0]  busRdata,
  output logic              warnIrq,
  output logic              resetReq
);
  wdStrobes_t        stb;
  logic              expired;
  logic [CountW-1:0] compareVal;
  logic [DataW-1:0]  offsetVal;

  wdog_ctrl #(.AddrW(AddrW), .DataW(DataW), .IdValue(IdValue), .CountW(CountW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busRefreshSel(busRefreshSel), .busAddr(busAddr), .busWdata(busWdata),
    .expired(expired), .compareVal(compareVal), .offsetVal(offsetVal),
    .stb(stb), .warnQ(warnIrq), .finalQ(resetReq), .busRdata(busRdata)
  );

  wdog_datapath #(.DataW(DataW), .CountW(CountW)) u_dp (
    .clk(clk), .rstN(rstN), .sysCount(sysCount), .busWdata(busWdata), .stb(stb),
    .expired(expired), .compareVal(compareVal), .offsetVal(offsetVal)
  );
endmodule

// File: tb/wdog_dual_stage_bench.sv
module wdog_dual_stage_bench;
  localparam logic [31:0] IdV = 32'h5744_0101;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] sysCount = '0;
  logic        busValid = 1'b0, busWrite = 1'b0, busRefreshSel = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        warnIrq, resetReq;

  int compared = 0, mismatched = 0;
  logic readSeen = 1'b0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  wdog_dual_stage #(.IdValue(IdV)) u_wdog_dual_stage (
    .clk(clk), .rstN(rstN), .sysCount(sysCount), .busValid(busValid),
    .busWrite(busWrite), .busRefreshSel(busRefreshSel), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .warnIrq(warnIrq), .resetReq(resetReq)
  );

  // monitor: records read issue at the edge, compares on the following falling edge
  always @(posedge clk) readSeen <= busValid && !busWrite;

  always @(negedge clk) begin
    if (readSeen) begin
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL monitor: read data %h with nothing expected", busRdata);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        compared++;
        if (busRdata !== it.exp) begin
          mismatched++;
          $display("FAIL %s: got %h expected %h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  // tasks are entered on a falling edge and return on a falling edge
  task automatic writeReg(input logic frame, input logic [11:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busRefreshSel = frame; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readReg(input logic frame, input logic [11:0] a, input logic [31:0] e,
                         input string tag);
    expItem_t it;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    busValid = 1'b1; busWrite = 1'b0; busRefreshSel = frame; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic pins(input logic w, input logic f, input string tag);
    compared++;
    if (warnIrq !== w || resetReq !== f) begin
      mismatched++;
      $display("FAIL %s: warn/final %b%b expected %b%b", tag, warnIrq, resetReq, w, f);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish");
      end
      begin
        idle(3);
        rstN = 1'b1;
        idle(1);
        // R1 reset state
        pins(0, 0, "R1 reset levels");
        readReg(0, 12'h000, 32'h0, "R1 status after reset");
        readReg(0, 12'h010, 32'h0, "R1 compare low after reset");
        readReg(0, 12'h008, 32'h0, "R1 interval after reset");
        // R8 id and unmapped
        readReg(0, 12'hFCC, IdV, "R8 id control frame");
        readReg(1, 12'hFCC, IdV, "R8 id refresh frame");
        readReg(0, 12'h020, 32'h0, "R8 unmapped offset");
        readReg(1, 12'h000, 32'h0, "R8 refresh register reads zero");
        // R10 / R3 interval write refreshes with the new value
        sysCount = 64'd1000;
        writeReg(0, 12'h008, 32'd100);
        readReg(0, 12'h008, 32'd100, "R10 interval readback");
        readReg(0, 12'h010, 32'd1100, "R3 interval write reload");
        // R2 enable
        writeReg(0, 12'h000, 32'h1);
        readReg(0, 12'h000, 32'h1, "R2 enable bit");
        // R4 first stage
        sysCount = 64'd1099;
        idle(1);
        pins(0, 0, "R4 one below expiry");
        sysCount = 64'd1100;
        idle(1);
        pins(1, 0, "R4 warning at expiry");
        readReg(0, 12'h010, 32'd1200, "R4 automatic reload");
        readReg(0, 12'h000, 32'h3, "R2 status with warning");
        // R5 second stage
        sysCount = 64'd1250;
        idle(1);
        pins(1, 1, "R5 final level");
        readReg(0, 12'h000, 32'h7, "R5 status both stages");
        // R3 refresh frame kick
        sysCount = 64'd2000;
        writeReg(1, 12'h000, 32'h0);
        pins(0, 0, "R3 refresh clears levels");
        readReg(0, 12'h010, 32'd2100, "R3 refresh reload");
        // R7 direct compare below count
        writeReg(0, 12'h014, 32'h0);
        pins(0, 0, "R7 high word keeps future expiry");
        writeReg(0, 12'h010, 32'd1500);
        pins(0, 0, "R9 no fire on writing cycle");
        idle(1);
        pins(1, 0, "R7 past compare fires");
        readReg(0, 12'h010, 32'd2100, "R7 reload after direct fire");
        // R9 write coincides with expiry
        writeReg(1, 12'h000, 32'h0);
        sysCount = 64'd3000;
        writeReg(0, 12'h014, 32'h0);
        pins(0, 0, "R9 write suppresses expiry");
        idle(1);
        pins(1, 0, "R9 expiry taken next cycle");
        // R7 high word
        sysCount = 64'd2000;
        writeReg(1, 12'h000, 32'h0);
        writeReg(0, 12'h014, 32'h1);
        sysCount = 64'd5000;
        idle(2);
        pins(0, 0, "R7 high word pushes expiry out");
        readReg(0, 12'h014, 32'h1, "R7 high word readback");
        // R6 disabled
        sysCount = 64'd3000;
        writeReg(0, 12'h000, 32'h0);
        sysCount = 64'd9000;
        idle(3);
        pins(0, 0, "R6 disabled never fires");
        readReg(0, 12'h000, 32'h0, "R6 status disabled");
        readReg(0, 12'h010, 32'd3100, "R6 compare held");
        // R10 zero extension and carry
        sysCount = 64'h10;
        writeReg(0, 12'h008, 32'hFFFF_FFFF);
        readReg(0, 12'h014, 32'h1, "R10 carry into high word");
        readReg(0, 12'h010, 32'hF, "R10 low word after carry");
        readReg(0, 12'h008, 32'hFFFF_FFFF, "R10 full interval readback");
        idle(2);
        if (expQ.size() != 0) begin
          mismatched++;
          $display("FAIL monitor: %0d reads never answered", expQ.size());
        end
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule